// File: doc/BRIEF.md
# Conversion Result Averager

This block sits on the path from a 10-bit converter's result port to the sample-sequencer FIFO. It can sum a power-of-two number of consecutive conversions and hand one mean value to the FIFO in their place. Each incoming sample is a beat with a valid strobe and a step tag. Each outgoing result is a beat with a valid strobe and the tag of the step that produced it. A ready signal from the FIFO can hold the output back.

There is one averaging path, and every input and every sequence step uses it. Whether a step is single-ended or differential makes no difference. A 3-bit factor code selects the window length. The code resets to zero, which means pass-through. Writing a new code drops any partly filled window. When a sample with a different tag arrives inside a window, that window is abandoned, a one-cycle error pulse is raised, and the new sample opens a fresh window.

Top module: `sample_averager`

## Requirements
- R1: After synchronous reset, `res_valid` and `tag_mismatch` are 0, `smp_ready` is 1, and the factor code is 0 (pass-through).
- R2: With factor code 0, every accepted sample appears on `res_data`/`res_tag` unchanged in the following cycle with `res_valid` set.
- R3: Factor code k in 0..6 selects a window of N = 2^k samples. Code 7 behaves exactly like code 6 (N = 64).
- R4: With code k > 0, one result is produced per N accepted samples. It appears in the cycle after the N-th sample is accepted and equals floor(sum / N), which is the sum shifted right by k.
- R5: A window of 64 samples of 0x3FF yields 0x3FF. The running sum never wraps.
- R6: N identical samples of value v yield exactly v, because the result is truncated and not rounded.
- R7: A result carries the step tag shared by every sample of its window.
- R8: If an accepted sample's tag differs from the tag of a non-empty open window, `tag_mismatch` is 1 for exactly the next cycle. The old samples are discarded without a result, and the new sample becomes sample 1 of a new window.
- R9: While `cfg_we` is high, `smp_ready` is 0. The write clears the open window and emits no partial result. A result already waiting at the output is kept.
- R10: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_data` and `res_tag` stay unchanged.
- R11: `smp_ready` is 1 exactly when `cfg_we` is 0 and the output register is empty or is being accepted in this cycle (`!res_valid || res_ready`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the factor code |
| cfg_code | input | 3 | Factor code k (N = 2^k, 0 = pass-through, 7 acts as 6) |
| smp_valid | input | 1 | Converter sample valid |
| smp_ready | output | 1 | Block can take a sample this cycle |
| smp_data | input | 10 | Unsigned converter sample |
| smp_tag | input | 4 | Sequence step tag of the sample |
| res_valid | output | 1 | Result valid toward the FIFO |
| res_ready | input | 1 | FIFO can take the result |
| res_data | output | 10 | Averaged or passed-through result |
| res_tag | output | 4 | Step tag of the result |
| tag_mismatch | output | 1 | One-cycle pulse: window restarted on a tag change |

## Verification
Assertions check several properties on every cycle. The output is held steady under backpressure. The ready signal drops whenever the output is blocked. The sample count stays below the window length. A factor write empties the window. A mismatch pulse is followed by a window holding exactly one sample. The running sum never exceeds the count times full scale. Pass-through samples reach the output one cycle after they are accepted. The values only the bench scenarios can show are these: the truncated mean of a full window, the clamp of code 7 to a 64-sample window, the loss of a partial window on reconfiguration, and the exact result count per stream. The bench compares the outputs against a behavioural model on every clock, with random data and random backpressure.

// File: rtl/avg_pkg.sv
package avg_pkg;

    localparam int DATA_W   = 10;
    localparam int TAG_W    = 4;
    localparam int CODE_W   = 3;
    localparam int MAX_LOG2 = 6;
    localparam int ACC_W    = DATA_W + MAX_LOG2;
    localparam int CNT_W    = MAX_LOG2 + 1;
    localparam int FULL     = (1 << DATA_W) - 1;

    typedef logic [DATA_W-1:0] sample_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {
        MODE_BYPASS  = 1'b0,
        MODE_AVERAGE = 1'b1
    } mode_e;

    typedef struct packed {
        sample_t data;
        tag_t    tag;
    } beat_t;

    // Codes above the largest supported exponent fold onto it.
    function automatic code_t clamp_code(code_t c);
        return (c > code_t'(MAX_LOG2)) ? code_t'(MAX_LOG2) : c;
    endfunction

    function automatic cnt_t window_len(code_t k);
        return cnt_t'(1) << k;
    endfunction

endpackage

// File: rtl/avg_cfg.sv
module avg_cfg
    import avg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cfg_we,
    input  code_t cfg_code,
    output code_t k,
    output mode_e mode,
    output cnt_t  win_len
);

    code_t k_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            k_q <= '0;
        end else if (cfg_we) begin
            k_q <= clamp_code(cfg_code);
        end
    end

    assign k       = k_q;
    assign mode    = (k_q == '0) ? MODE_BYPASS : MODE_AVERAGE;
    assign win_len = window_len(k_q);

    // R3: the stored exponent never exceeds the supported maximum
    a_r3_code_range: assert property (@(posedge clk) disable iff (rst)
        k_q <= code_t'(MAX_LOG2));

endmodule

// File: rtl/avg_window.sv
module avg_window
    import avg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic take,
    input  tag_t tag,
    input  cnt_t win_len,
    output logic restart,
    output logic last,
    output cnt_t count,
    output logic tag_err
);

    cnt_t count_q;
    tag_t win_tag_q;
    logic err_q;
    cnt_t base_cnt;

    always_comb begin
        restart  = take && (count_q != '0) && (tag != win_tag_q);
        base_cnt = restart ? '0 : count_q;
        last     = take && ((base_cnt + cnt_t'(1)) == win_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            win_tag_q <= '0;
            err_q     <= 1'b0;
        end else begin
            err_q <= restart;
            if (clr) begin
                count_q <= '0;
            end else if (take) begin
                count_q   <= last ? '0 : base_cnt + cnt_t'(1);
                win_tag_q <= tag;
            end
        end
    end

    assign count   = count_q;
    assign tag_err = err_q;

    // R4: the open window never reaches its full length
    a_r4_count_below_len: assert property (@(posedge clk) disable iff (rst)
        count_q < win_len);

    // R9: a factor write leaves an empty window
    a_r9_clear_on_write: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count_q == '0));

endmodule

// File: rtl/avg_accum.sv
module avg_accum
    import avg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    take,
    input  logic    restart,
    input  logic    last,
    input  sample_t data,
    input  code_t   k,
    output sample_t mean,
    output acc_t    acc
);

    acc_t acc_q;
    acc_t sum;

    always_comb begin
        sum  = (restart ? acc_t'(0) : acc_q) + acc_t'(data);
        mean = sample_t'(sum >> k);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (take) begin
            acc_q <= last ? '0 : sum;
        end
    end

    assign acc = acc_q;

    // R5: adding a sample never wraps the running sum
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (take && !restart) |-> (sum >= acc_q));

endmodule

// File: rtl/avg_outreg.sv
module avg_outreg
    import avg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  beat_t beat_in,
    input  logic  out_ready,
    output logic  out_valid,
    output beat_t beat_out,
    output logic  space
);

    logic  valid_q;
    beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            beat_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            beat_q  <= beat_in;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign out_valid = valid_q;
    assign beat_out  = beat_q;
    assign space     = !valid_q || out_ready;

    // R10: a blocked result stays put
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !out_ready) |=> (valid_q && $stable(beat_q)));

endmodule

// File: rtl/sample_averager.sv
module sample_averager
    import avg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [CODE_W-1:0]   cfg_code,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [DATA_W-1:0]   smp_data,
    input  logic [TAG_W-1:0]    smp_tag,
    output logic                res_valid,
    input  logic                res_ready,
    output logic [DATA_W-1:0]   res_data,
    output logic [TAG_W-1:0]    res_tag,
    output logic                tag_mismatch
);

    code_t   k;
    mode_e   mode;
    cnt_t    win_len;
    cnt_t    count;
    acc_t    acc;
    sample_t mean;
    logic    space, accept, take, restart, last, load;
    beat_t   beat_in, beat_out;

    avg_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (cfg_we),
        .cfg_code(cfg_code),
        .k       (k),
        .mode    (mode),
        .win_len (win_len)
    );

    assign smp_ready = space && !cfg_we;
    assign accept    = smp_valid && smp_ready;
    assign take      = accept && (mode == MODE_AVERAGE);

    avg_window u_window (
        .clk    (clk),
        .rst    (rst),
        .clr    (cfg_we),
        .take   (take),
        .tag    (smp_tag),
        .win_len(win_len),
        .restart(restart),
        .last   (last),
        .count  (count),
        .tag_err(tag_mismatch)
    );

    avg_accum u_accum (
        .clk    (clk),
        .rst    (rst),
        .clr    (cfg_we),
        .take   (take),
        .restart(restart),
        .last   (last),
        .data   (smp_data),
        .k      (k),
        .mean   (mean),
        .acc    (acc)
    );

    always_comb begin
        load         = accept && ((mode == MODE_BYPASS) || last);
        beat_in.tag  = smp_tag;
        beat_in.data = (mode == MODE_BYPASS) ? smp_data : mean;
    end

    avg_outreg u_out (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .beat_in  (beat_in),
        .out_ready(res_ready),
        .out_valid(res_valid),
        .beat_out (beat_out),
        .space    (space)
    );

    assign res_data = beat_out.data;
    assign res_tag  = beat_out.tag;

    // R11: no sample is taken while the result register is blocked
    a_r11_stall_when_full: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |-> !smp_ready);

    // R8: a mismatch pulse leaves a window holding only the new sample
    a_r8_restart_count: assert property (@(posedge clk) disable iff (rst)
        (tag_mismatch && !$past(cfg_we)) |-> (count == cnt_t'(1)));

    // R5: running sum bounded by count times full scale
    a_r5_sum_bound: assert property (@(posedge clk) disable iff (rst)
        (32'(acc) <= 32'(count) * FULL));

    // R2: pass-through sample shows up unchanged one cycle later
    a_r2_bypass_path: assert property (@(posedge clk) disable iff (rst)
        (accept && mode == MODE_BYPASS) |=>
            (res_valid && res_data == $past(smp_data) && res_tag == $past(smp_tag)));

endmodule

// File: tb/sample_averager_tb.sv
module sample_averager_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_code = '0;
    logic       smp_valid = 1'b0;
    logic       smp_ready;
    logic [9:0] smp_data = '0;
    logic [3:0] smp_tag = '0;
    logic       res_valid;
    logic       res_ready = 1'b1;
    logic [9:0] res_data;
    logic [3:0] res_tag;
    logic       tag_mismatch;

    int n_chk = 0;
    int n_fail = 0;
    int n_out = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural model state
    int m_k = 0, m_cnt = 0, m_sum = 0, m_tag = 0;
    bit m_ov = 0, m_err = 0;
    int m_od = 0, m_ot = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sample_averager u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_code(cfg_code),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
        .smp_tag(smp_tag), .res_valid(res_valid), .res_ready(res_ready),
        .res_data(res_data), .res_tag(res_tag), .tag_mismatch(tag_mismatch)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        chk(cur_req, "res_valid", int'(res_valid), int'(m_ov));
        chk(cur_req, "tag_mismatch", int'(tag_mismatch), int'(m_err));
        if (m_ov) begin
            chk(cur_req, "res_data", int'(res_data), m_od);
            chk(cur_req, "res_tag", int'(res_tag), m_ot);
        end
    endtask

    // Called at a falling edge: drive, check ready, advance model, sample after next rise.
    task automatic step(bit we, int code, bit v, int d, int t, bit rdy);
        bit exp_ready, fire;
        cfg_we = we; cfg_code = 3'(code);
        smp_valid = v; smp_data = 10'(d); smp_tag = 4'(t); res_ready = rdy;
        #1;
        exp_ready = (!m_ov || rdy) && !we;
        chk((cur_req == "R10") ? "R11" : cur_req, "smp_ready", int'(smp_ready), int'(exp_ready));
        if (m_ov && rdy) begin
            n_out++;
            m_ov = 0;
        end
        m_err = 0;
        fire = v && exp_ready;
        if (we) begin
            m_k = (code > 6) ? 6 : code;
            m_cnt = 0; m_sum = 0;
        end else if (fire) begin
            if (m_k == 0) begin
                m_ov = 1; m_od = d; m_ot = t;
            end else begin
                if (m_cnt > 0 && t != m_tag) begin
                    m_err = 1; m_cnt = 0; m_sum = 0;
                end
                m_sum += d; m_cnt++; m_tag = t;
                if (m_cnt == (1 << m_k)) begin
                    m_ov = 1; m_od = m_sum >> m_k; m_ot = t;
                    m_cnt = 0; m_sum = 0;
                end
            end
        end
        @(negedge clk);
        compare_outputs();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1);
    endtask

    // Feed n samples with the same tag, never stalled by the output.
    task automatic feed(int n, int val, int t, bit rnd);
        for (int i = 0; i < n; i++)
            step(0, 0, 1, rnd ? int'($urandom_range(0, 1023)) : val, t, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        cur_req = "R1";
        #1;
        chk("R1", "smp_ready", int'(smp_ready), 1);
        compare_outputs();
        @(negedge clk);

        // R2: pass-through stream
        cur_req = "R2";
        for (int i = 0; i < 20; i++)
            step(0, 0, 1, $urandom_range(0, 1023), i % 16, 1);
        idle(2);

        // R4 / R7: window of 4, random data, tag 3
        cur_req = "R4";
        step(1, 2, 0, 0, 0, 1);
        n_out = 0;
        feed(16, 0, 3, 1);
        idle(2);
        chk("R4", "results per 16 samples", n_out, 4);
        cur_req = "R7";
        feed(8, 0, 9, 1);
        idle(2);

        // R5 / R6: 64 samples at full scale, then identical mid-scale
        cur_req = "R5";
        step(1, 6, 0, 0, 0, 1);
        feed(64, 1023, 5, 0);
        idle(1);
        cur_req = "R6";
        feed(64, 'h155, 2, 0);
        step(1, 3, 0, 0, 0, 1);
        feed(8, 'h2a7, 1, 0);
        idle(1);

        // R3: code 7 acts as a 64-sample window
        cur_req = "R3";
        step(1, 7, 0, 0, 0, 1);
        n_out = 0;
        feed(63, 0, 4, 1);
        idle(1);
        chk("R3", "no result before 64th", n_out, 0);
        feed(1, 0, 4, 1);
        idle(2);
        chk("R3", "one result after 64th", n_out, 1);
        step(1, 1, 0, 0, 0, 1);
        feed(6, 0, 8, 1);
        idle(1);

        // R8: tag change in the middle of a window
        cur_req = "R8";
        step(1, 3, 0, 0, 0, 1);
        feed(5, 0, 1, 1);
        feed(8, 0, 2, 1);
        feed(3, 0, 6, 1);
        feed(8, 0, 7, 1);
        idle(2);

        // R9: write mid-window drops partial sums; pending result kept
        cur_req = "R9";
        step(1, 2, 0, 0, 0, 1);
        feed(3, 0, 1, 1);
        step(1, 2, 1, 100, 1, 1);
        n_out = 0;
        feed(4, 40, 1, 0);
        idle(2);
        chk("R9", "single clean result", n_out, 1);
        feed(4, 0, 2, 1);
        step(1, 1, 1, 0, 2, 0);
        step(0, 0, 0, 0, 0, 1);
        idle(1);

        // R10 / R11: random backpressure in both modes
        cur_req = "R10";
        step(1, 1, 0, 0, 0, 1);
        for (int i = 0; i < 300; i++)
            step(0, 0, $urandom_range(0, 1), $urandom_range(0, 1023), 3, $urandom_range(0, 2) == 0);
        step(1, 0, 0, 0, 0, 1);
        for (int i = 0; i < 200; i++)
            step(0, 0, $urandom_range(0, 1), $urandom_range(0, 1023), i % 16, $urandom_range(0, 1));
        idle(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule